// File: doc/BRIEF.md
# Lane-Mask Divergence Control Unit

This unit steers if/else divergence for one 64-lane wavefront without any per-lane branching. It keeps an execution mask that tells the vector datapath which lanes may write results, a condition mask that a vector compare fills with one bit per lane, and a small file of 64-bit scalar registers that hold masks saved around a divergent region.

A short set of scalar mask instructions drives it. The "if" step saves the execution mask to a scalar register and narrows it to the lanes whose condition bit is set. The "else" step flips to the lanes that were active before the "if" but are not active now. The closing step copies the saved mask back. A conditional branch tells fetch to skip a path, and it is taken only when no lane is active. Every instruction completes in one clock, and its result is visible to the instruction issued in the following cycle.

Top module: `lane_div_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the execution mask becomes all ones, the condition mask becomes all zeros, every scalar register becomes all zeros and `br_taken` becomes 0.
- R2: When `cmp_valid` is 1 at a rising edge, the condition mask becomes `cmp_result` AND the execution mask as it was before that edge, so lanes that are inactive end up with a 0 bit. With `cmp_valid` at 0 the condition mask does not change.
- R3: Opcode 1 (save-and-narrow) with `op_valid` at 1 writes the current execution mask into scalar register `op_sreg` and, at the same edge, sets the execution mask to the old condition mask AND the old execution mask.
- R4: Opcode 2 (invert-within-saved) sets the execution mask to scalar register `op_sreg` AND NOT the current execution mask.
- R5: Opcode 3 (restore) copies scalar register `op_sreg` into the execution mask.
- R6: Opcode 4 (skip-if-idle) raises `br_taken` for exactly the one cycle after the edge that accepts it, and only if the execution mask was all zeros when it was accepted. In that cycle `br_target` equals the `op_target` that came with the instruction. In any other cycle `br_taken` is 0.
- R7: A compare and a mask instruction accepted at the same edge both read the values held before that edge. Save-and-narrow then uses the old condition mask, not the new one.
- R8: Opcodes 0, 5, 6 and 7, and any opcode with `op_valid` at 0, leave the execution mask and every scalar register unchanged and do not raise `br_taken`.
- R9: The 16 scalar registers can be addressed independently. Saving to one index leaves every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (wavefront start) |
| op_valid | input | 1 | A mask instruction is issued this cycle |
| op_code | input | 3 | Instruction opcode (0 none, 1 save-and-narrow, 2 invert-within-saved, 3 restore, 4 skip-if-idle) |
| op_sreg | input | 4 | Scalar register index for the instruction |
| op_target | input | 32 | Absolute branch address for skip-if-idle |
| cmp_valid | input | 1 | A vector compare writes the condition mask this cycle |
| cmp_result | input | 64 | Per-lane compare result |
| exec_mask | output | 64 | Current execution mask to the vector datapath |
| vcc_mask | output | 64 | Current condition mask |
| br_taken | output | 1 | One-cycle pulse telling fetch to redirect |
| br_target | output | 32 | Redirect address, valid while `br_taken` is 1 |

## Verification
The bench builds the unit with its default parameters: 64 lanes, 16 scalar registers and a 32-bit address. At this width a random compare almost never clears every lane, so the stimulus draws its compare patterns from a biased set of all-zero, all-one, sparse and random values. That makes the all-idle branch case and the fully-populated mask reachable many times within a short run. Because every one of the 16 indices is exercised, nesting across saved registers and the rule that other entries stay untouched both get covered, along with a reset issued mid-run on a dirty register file.

// File: rtl/lane_div_pkg.sv
// Package: shared opcode encoding for the lane-mask divergence control unit.
// Assumes a 3-bit opcode field; codes 5..7 are reserved and act as no-ops.
package lane_div_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE     = 3'd0,
        OP_SAVE_AND = 3'd1,
        OP_INV_SAVE = 3'd2,
        OP_RESTORE  = 3'd3,
        OP_SKIP_IDL = 3'd4
    } mask_op_t;

endpackage

// File: rtl/lane_div_sreg_file.sv
// Module: scalar mask register file with one write port and one read port.
// Assumes write and read in the same cycle return the old contents (the
// read port is combinational, the write takes effect at the clock edge).
module lane_div_sreg_file #(
    parameter int LANES      = 64,
    parameter int SREG_COUNT = 16,
    localparam int IDX_W     = $clog2(SREG_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LANES-1:0] rd_data
);

    logic [LANES-1:0] regs_q [SREG_COUNT];

    // Purpose: clear all entries on reset, otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SREG_COUNT; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    // Purpose: combinational read of the addressed entry.
    always_comb begin
        rd_data = regs_q[rd_idx];
    end

    // R9: a written entry holds the written data on the next cycle.
    assert_wr_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/lane_div_mask_unit.sv
// Module: holds the execution and condition masks and applies the mask
// instructions. Assumes at most one mask instruction per cycle; a compare
// may arrive in the same cycle and both read the pre-edge state.
module lane_div_mask_unit
    import lane_div_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  mask_op_t         op,
    input  logic [LANES-1:0] saved_mask,
    input  logic             cmp_valid,
    input  logic [LANES-1:0] cmp_result,
    output logic [LANES-1:0] exec_q,
    output logic [LANES-1:0] vcc_q,
    output logic             save_we
);

    logic [LANES-1:0] exec_d;
    logic [LANES-1:0] vcc_d;

    // Purpose: decode the write strobe for the scalar register file.
    always_comb begin
        save_we = op_valid && (op == OP_SAVE_AND);
    end

    // Purpose: next execution mask from the issued mask instruction.
    always_comb begin
        exec_d = exec_q;
        if (op_valid) begin
            unique case (op)
                OP_SAVE_AND: exec_d = vcc_q & exec_q;
                OP_INV_SAVE: exec_d = saved_mask & ~exec_q;
                OP_RESTORE:  exec_d = saved_mask;
                default:     exec_d = exec_q;
            endcase
        end
    end

    // Purpose: next condition mask, limited to the currently active lanes.
    always_comb begin
        vcc_d = cmp_valid ? (cmp_result & exec_q) : vcc_q;
    end

    // Purpose: mask registers with wavefront-start reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q <= '1;
            vcc_q  <= '0;
        end else begin
            exec_q <= exec_d;
            vcc_q  <= vcc_d;
        end
    end

    // R1: the first cycle out of reset shows the start-up masks.
    assert_reset_masks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (exec_q == '1 && vcc_q == '0));

    // R2: after a compare no inactive lane carries a condition bit.
    assert_vcc_inactive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> ((vcc_q & ~$past(exec_q)) == '0));

    // R3: save-and-narrow can only remove lanes, never add them.
    assert_save_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SAVE_AND) |=> ((exec_q & ~$past(exec_q)) == '0));

    // R4: invert-within-saved never keeps a lane that was active before.
    assert_inv_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_INV_SAVE) |=> ((exec_q & $past(exec_q)) == '0));

    // R8: without a mask-writing instruction the execution mask holds.
    assert_exec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && (op == OP_SAVE_AND || op == OP_INV_SAVE || op == OP_RESTORE))
        |=> $stable(exec_q));

endmodule

// File: rtl/lane_div_branch_unit.sv
// Module: resolves the skip-if-idle branch. Assumes the execution mask
// seen here is the value before the edge that accepts the branch.
module lane_div_branch_unit
    import lane_div_pkg::*;
#(
    parameter int LANES  = 64,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  mask_op_t          op,
    input  logic [LANES-1:0]  exec_mask,
    input  logic [ADDR_W-1:0] target,
    output logic              taken_q,
    output logic [ADDR_W-1:0] target_q
);

    logic all_idle;
    logic take_d;

    // Purpose: detect that no lane is active and the branch is issued.
    always_comb begin
        all_idle = (exec_mask == '0);
        take_d   = op_valid && (op == OP_SKIP_IDL) && all_idle;
    end

    // Purpose: one-cycle taken pulse and its captured target address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q  <= 1'b0;
            target_q <= '0;
        end else begin
            taken_q <= take_d;
            if (take_d) begin
                target_q <= target;
            end
        end
    end

    // R6: an issued branch with no active lane redirects to its own target.
    assert_br_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SKIP_IDL && exec_mask == '0)
        |=> (taken_q && target_q == $past(target)));

    // R6: no redirect follows a cycle without an issued branch.
    assert_br_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op == OP_SKIP_IDL) |=> !taken_q);

    // R6: a branch issued while some lane is active falls through.
    assert_br_fallthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SKIP_IDL && exec_mask != '0) |=> !taken_q);

endmodule

// File: rtl/lane_div_ctrl.sv
// Module: top of the lane-mask divergence control unit. Connects the mask
// unit, the scalar register file and the branch resolver. Assumes one
// mask instruction per cycle and that fetch honours br_taken immediately.
module lane_div_ctrl
    import lane_div_pkg::*;
#(
    parameter int LANES      = 64,
    parameter int SREG_COUNT = 16,
    parameter int ADDR_W     = 32,
    localparam int IDX_W     = $clog2(SREG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [IDX_W-1:0]  op_sreg,
    input  logic [ADDR_W-1:0] op_target,
    input  logic              cmp_valid,
    input  logic [LANES-1:0]  cmp_result,
    output logic [LANES-1:0]  exec_mask,
    output logic [LANES-1:0]  vcc_mask,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target
);

    mask_op_t         op;
    logic [LANES-1:0] saved_mask;
    logic             save_we;

    // Purpose: interpret the raw opcode field as the shared enum.
    always_comb begin
        op = mask_op_t'(op_code);
    end

    lane_div_sreg_file #(
        .LANES      (LANES),
        .SREG_COUNT (SREG_COUNT)
    ) u_sregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (save_we),
        .wr_idx  (op_sreg),
        .wr_data (exec_mask),
        .rd_idx  (op_sreg),
        .rd_data (saved_mask)
    );

    lane_div_mask_unit #(
        .LANES (LANES)
    ) u_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op         (op),
        .saved_mask (saved_mask),
        .cmp_valid  (cmp_valid),
        .cmp_result (cmp_result),
        .exec_q     (exec_mask),
        .vcc_q      (vcc_mask),
        .save_we    (save_we)
    );

    lane_div_branch_unit #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_branch (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op        (op),
        .exec_mask (exec_mask),
        .target    (op_target),
        .taken_q   (br_taken),
        .target_q  (br_target)
    );

endmodule

// File: tb/lane_div_ctrl_bench.sv
// Bench: fixed-seed random mask instructions and compares mixed with
// directed if/else, all-idle and reset cases, checked against a model.
module lane_div_ctrl_bench;

    localparam int LANES  = 64;
    localparam int NREG   = 16;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [2:0]        op_code = '0;
    logic [3:0]        op_sreg = '0;
    logic [ADDR_W-1:0] op_target = '0;
    logic              cmp_valid = 1'b0;
    logic [LANES-1:0]  cmp_result = '0;
    logic [LANES-1:0]  exec_mask;
    logic [LANES-1:0]  vcc_mask;
    logic              br_taken;
    logic [ADDR_W-1:0] br_target;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [LANES-1:0] m_exec;
    logic [LANES-1:0] m_vcc;
    logic [LANES-1:0] m_sreg [NREG];

    always #10 clk = ~clk;

    lane_div_ctrl u_lane_div_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .op_sreg    (op_sreg),
        .op_target  (op_target),
        .cmp_valid  (cmp_valid),
        .cmp_result (cmp_result),
        .exec_mask  (exec_mask),
        .vcc_mask   (vcc_mask),
        .br_taken   (br_taken),
        .br_target  (br_target)
    );

    task automatic chk(input string req, input logic [LANES-1:0] act,
                       input logic [LANES-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string exec_tag(input logic v, input logic [2:0] c);
        if (!v) return "R8";
        case (c)
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [LANES-1:0] next_exec(input logic v, input logic [2:0] c,
                                                   input logic [3:0] idx);
        if (!v) return m_exec;
        case (c)
            3'd1:    return m_vcc & m_exec;
            3'd2:    return m_sreg[idx] & ~m_exec;
            3'd3:    return m_sreg[idx];
            default: return m_exec;
        endcase
    endfunction

    task automatic model_reset();
        m_exec = '1;
        m_vcc  = '0;
        for (int i = 0; i < NREG; i++) m_sreg[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        cmp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R1", exec_mask, '1);
        chk("R1", vcc_mask, '0);
        chk("R1", {63'd0, br_taken}, '0);
    endtask

    // One cycle: drive at negedge, sample 2 ns after the next rising edge.
    task automatic step(input logic v, input logic [2:0] c, input logic [3:0] idx,
                        input logic [ADDR_W-1:0] tgt, input logic cv,
                        input logic [LANES-1:0] cr);
        logic [LANES-1:0] e_exec, e_vcc;
        logic e_br;
        string tag;
        @(negedge clk);
        op_valid = v; op_code = c; op_sreg = idx; op_target = tgt;
        cmp_valid = cv; cmp_result = cr;
        e_exec = next_exec(v, c, idx);
        e_vcc  = cv ? (cr & m_exec) : m_vcc;
        e_br   = v && (c == 3'd4) && (m_exec == '0);
        tag    = exec_tag(v, c);
        if (v && c == 3'd1) m_sreg[idx] = m_exec;
        @(posedge clk);
        #2;
        chk(tag, exec_mask, e_exec);
        chk(cv ? "R2" : "R7", vcc_mask, e_vcc);
        chk("R6", {63'd0, br_taken}, {63'd0, e_br});
        if (e_br) chk("R6", {32'd0, br_target}, {32'd0, tgt});
        m_exec = e_exec;
        m_vcc  = e_vcc;
    endtask

    function automatic logic [LANES-1:0] pick_cmp();
        case ($urandom % 5)
            0:       return '0;
            1:       return '1;
            2:       return {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            3:       return {$urandom, $urandom} & {$urandom, $urandom};
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R9: after reset every register reads zero, seen through restore.
        step(1, 3'd3, 4'd9, '0, 0, '0);
        step(1, 3'd4, 4'd0, 32'h0000_0400, 0, '0);   // R6: all idle, taken
        step(0, 3'd0, 4'd0, '0, 0, '0);               // R6: pulse ends
        do_reset();

        // Directed if/else region: R2, R3, R6 fall-through, R4, R5.
        step(0, 3'd0, 4'd0, '0, 1, 64'hF0F0_0000_FFFF_1234);
        step(1, 3'd1, 4'd3, '0, 0, '0);
        step(1, 3'd4, 4'd0, 32'h0000_0100, 0, '0);
        step(1, 3'd2, 4'd3, '0, 0, '0);
        step(1, 3'd4, 4'd0, 32'h0000_0200, 0, '0);
        step(1, 3'd3, 4'd3, '0, 0, '0);
        chk("R5", exec_mask, '1);

        // All lanes fail: branch taken with its target (R6).
        step(0, 3'd0, 4'd0, '0, 1, '0);
        step(1, 3'd1, 4'd5, '0, 0, '0);
        step(1, 3'd4, 4'd0, 32'hDEAD_BEE0, 0, '0);
        step(1, 3'd3, 4'd5, '0, 0, '0);

        // R7: compare and save-and-narrow in one cycle use old VCC.
        step(1, 3'd1, 4'd7, '0, 1, 64'h1);
        step(1, 3'd3, 4'd7, '0, 0, '0);

        // R8: reserved opcodes and op_valid low with real opcodes.
        step(1, 3'd5, 4'd7, 32'h10, 0, '0);
        step(1, 3'd6, 4'd7, 32'h20, 0, '0);
        step(1, 3'd7, 4'd7, 32'h30, 0, '0);
        step(0, 3'd1, 4'd7, 32'h40, 0, '0);
        step(0, 3'd4, 4'd7, 32'h50, 0, '0);

        // Random phase with a mid-run reset on a dirty file.
        for (int k = 0; k < 3000; k++) begin
            step($urandom % 8 != 0, 3'($urandom % 8), 4'($urandom % NREG),
                 $urandom, $urandom % 3 == 0, pick_cmp());
            if (k == 1500) do_reset();
        end

        // R9: every register restored back; model tracks all 16 indices.
        for (int i = 0; i < NREG; i++) step(1, 3'd3, 4'(i), '0, 0, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule